// File: doc/BRIEF.md
# Array Signature Scan Engine

The engine walks every word of the memory blocks that are selected and not locked. It reads each word through a plain synchronous read port and folds the word into a 32-bit multiple-input signature register (MISR). Software seeds the signature and starts the scan by writing a run bit in a small control register. It then waits for the done flag and compares the signature with a known-good value. Starting is refused while the array is being programmed, erased or has its high voltage enabled.

Two address orders are offered. The ascending order visits the words of each eligible block one per cycle. The scrambled order visits them in bit-reversed word order and leaves an idle cycle after every read, so it loads the read paths differently and takes twice as long. While a scan runs, the control register keeps its mode bit and the signature seed locked.

Top module: `sig_scan_engine`

## Requirements
- R1: After reset, the control read value is done=1 (bit 0), run=0 (bit 1) and order=0 (bit 2). The signature is 0 and no read is issued.
- R2: A start covers only blocks whose select bit is 1 and whose lock bit is 0. The select and lock masks are sampled at the start write, and each word of a covered block is read exactly once. The read address is {block index, word index}, with 3 word bits per block.
- R3: A control write with run=1 is ignored for starting while any of the erase, program or high-voltage inputs is high. In that case done stays 1, run stays 0 and no read occurs.
- R4: A start write (run bit 1 written while done=1) clears done and sets run after that clock edge. At completion done returns to 1 and run clears on the same edge.
- R5: With order=1 (bit 2 written with the start), the block's word addresses rise by one on every cycle. Done is seen E+1 cycles after the start edge, where E is the number of words covered.
- R6: With order=0, words within each block are visited in bit-reversed index order, with one idle cycle after each read. Done is seen 2E cycles after the start edge.
- R7: Each read word d updates the signature s to (s<<1) ^ (s[31] ? 32'h0040_0007 : 0) ^ d. This is the polynomial x^32+x^22+x^2+x+1. A seed write while done=1 loads the signature directly.
- R8: While done=0, control writes and seed writes have no effect, and the order bit reads as 0.
- R9: If no block is both selected and unlocked, done is 1 again one cycle after the start edge and the signature keeps its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write data: bit 1 run, bit 2 order |
| cfg_rdata | output | 3 | Control read data: bit 0 done, bit 1 run, bit 2 order |
| sig_we | input | 1 | Signature seed write strobe |
| sig_wdata | input | 32 | Signature seed value |
| sig_value | output | 32 | Current signature |
| pe_erase | input | 1 | Erase in progress |
| pe_prog | input | 1 | Program in progress |
| pe_hv | input | 1 | High voltage enabled |
| blk_sel | input | 4 | Per-block select mask |
| blk_lock | input | 4 | Per-block lock mask |
| mem_re | output | 1 | Array read enable |
| mem_addr | output | 5 | Array read address |
| mem_rdata | input | 32 | Array read data, valid one cycle after the address |

## Verification
The first address appears in the cycle after the start edge. Its data returns one cycle later and is folded into the signature on the following edge. So the signature and the done flag settle E+1 edges after the start in ascending order, 2E edges in the scrambled order, and one edge when no block is covered. The bench drives on falling edges and samples on falling edges. It counts the falling edges between the start write and the first done=1, and compares that count with these figures. It logs every address seen with the read enable high, then compares that list and the final signature with a model computed from the masks, the order and the seed.

// File: rtl/sig_scan_pkg.sv
package sig_scan_pkg;
  localparam int SIG_W   = 32;
  localparam logic [SIG_W-1:0] SIG_POLY = 32'h0040_0007;
  localparam int CTL_W   = 3;
  localparam int CTL_DONE  = 0;
  localparam int CTL_RUN   = 1;
  localparam int CTL_ORDER = 2;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_ISSUE = 2'd1,
    SC_GAP   = 2'd2,
    SC_DRAIN = 2'd3
  } scan_state_e;
endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int NUM_BLK = 4,
  parameter int BLK_AW  = 3,
  localparam int BW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int AW = BW + BLK_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               step,
  input  logic               asc,
  input  logic [NUM_BLK-1:0] mask_in,
  output logic               any_elig,
  output logic               last,
  output logic [AW-1:0]      addr
);
  logic [NUM_BLK-1:0] mask_q, mask_d;
  logic [BW-1:0]      blk_q, blk_d, first_blk, next_blk;
  logic [BLK_AW-1:0]  wrd_q, wrd_d, ord;
  logic               has_next, wrd_end;

  assign any_elig = |mask_in;
  assign wrd_end  = &wrd_q;

  always_comb begin
    first_blk = '0;
    for (int i = NUM_BLK - 1; i >= 0; i--)
      if (mask_in[i]) first_blk = BW'(i);
  end

  always_comb begin
    next_blk = blk_q;
    has_next = 1'b0;
    for (int i = NUM_BLK - 1; i >= 0; i--)
      if (mask_q[i] && (BW'(i) > blk_q)) begin
        next_blk = BW'(i);
        has_next = 1'b1;
      end
  end

  assign last = wrd_end && !has_next;

  generate
    for (genvar g = 0; g < BLK_AW; g++) begin : g_ord
      assign ord[g] = asc ? wrd_q[g] : wrd_q[BLK_AW-1-g];
    end
  endgenerate

  assign addr = {blk_q, ord};

  always_comb begin
    mask_d = mask_q;
    blk_d  = blk_q;
    wrd_d  = wrd_q;
    if (init) begin
      mask_d = mask_in;
      blk_d  = first_blk;
      wrd_d  = '0;
    end else if (step) begin
      if (wrd_end) begin
        wrd_d = '0;
        blk_d = next_blk;
      end else begin
        wrd_d = wrd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      blk_q  <= '0;
      wrd_q  <= '0;
    end else if (init || step) begin
      mask_q <= mask_d;
      blk_q  <= blk_d;
      wrd_q  <= wrd_d;
    end
  end
endmodule

// File: rtl/sig_misr.sv
module sig_misr
  import sig_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_en,
  input  logic [SIG_W-1:0] seed,
  input  logic             fold_en,
  input  logic [SIG_W-1:0] din,
  output logic [SIG_W-1:0] sig
);
  logic [SIG_W-1:0] sig_q, sig_d, shifted;

  assign shifted = {sig_q[SIG_W-2:0], 1'b0} ^ (sig_q[SIG_W-1] ? SIG_POLY : '0);

  always_comb begin
    sig_d = sig_q;
    if (seed_en)      sig_d = seed;
    else if (fold_en) sig_d = shifted ^ din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sig_q <= '0;
    else if (seed_en || fold_en) sig_q <= sig_d;
  end

  assign sig = sig_q;
endmodule

// File: rtl/scan_ctl.sv
module scan_ctl
  import sig_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CTL_W-1:0] cfg_wdata,
  output logic [CTL_W-1:0] cfg_rdata,
  input  logic             pe_busy,
  input  logic             sig_we,
  input  logic             any_elig,
  input  logic             last,
  output logic             init,
  output logic             step,
  output logic             asc,
  output logic             seed_en,
  output logic             fold_en,
  output logic             rd_en
);
  scan_state_e state_q, state_d;
  logic done_q, done_d, run_q, run_d, order_q, order_d, rdv_q;
  logic start, wr_ok;

  assign wr_ok = cfg_we && done_q;
  assign start = wr_ok && cfg_wdata[CTL_RUN] && !pe_busy;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    run_d   = run_q;
    order_d = order_q;
    if (wr_ok) order_d = cfg_wdata[CTL_ORDER];
    case (state_q)
      SC_IDLE: if (start) begin
        done_d  = 1'b0;
        run_d   = 1'b1;
        state_d = any_elig ? SC_ISSUE : SC_DRAIN;
      end
      SC_ISSUE: begin
        if (last)          state_d = SC_DRAIN;
        else if (!order_q) state_d = SC_GAP;
      end
      SC_GAP:   state_d = SC_ISSUE;
      SC_DRAIN: begin
        state_d = SC_IDLE;
        done_d  = 1'b1;
        run_d   = 1'b0;
      end
      default:  state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      done_q  <= 1'b1;
      run_q   <= 1'b0;
      order_q <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      run_q   <= run_d;
      order_q <= order_d;
      rdv_q   <= rd_en;
    end
  end

  assign rd_en   = (state_q == SC_ISSUE);
  assign init    = start;
  assign step    = rd_en;
  assign asc     = order_q;
  assign seed_en = sig_we && done_q;
  assign fold_en = rdv_q;

  always_comb begin
    cfg_rdata            = '0;
    cfg_rdata[CTL_DONE]  = done_q;
    cfg_rdata[CTL_RUN]   = run_q;
    cfg_rdata[CTL_ORDER] = done_q && order_q;
  end
endmodule

// File: rtl/sig_scan_engine.sv
module sig_scan_engine
  import sig_scan_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int BLK_AW  = 3,
  localparam int BW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int AW = BW + BLK_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CTL_W-1:0]   cfg_wdata,
  output logic [CTL_W-1:0]   cfg_rdata,
  input  logic               sig_we,
  input  logic [SIG_W-1:0]   sig_wdata,
  output logic [SIG_W-1:0]   sig_value,
  input  logic               pe_erase,
  input  logic               pe_prog,
  input  logic               pe_hv,
  input  logic [NUM_BLK-1:0] blk_sel,
  input  logic [NUM_BLK-1:0] blk_lock,
  output logic               mem_re,
  output logic [AW-1:0]      mem_addr,
  input  logic [SIG_W-1:0]   mem_rdata
);
  logic init, step, scan_asc, seed_en, fold_en, any_elig, last;

  scan_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pe_busy(pe_erase | pe_prog | pe_hv), .sig_we(sig_we),
    .any_elig(any_elig), .last(last),
    .init(init), .step(step), .asc(scan_asc),
    .seed_en(seed_en), .fold_en(fold_en), .rd_en(mem_re)
  );

  scan_addr_gen #(.NUM_BLK(NUM_BLK), .BLK_AW(BLK_AW)) u_agen (
    .clk(clk), .rst_n(rst_n), .init(init), .step(step), .asc(scan_asc),
    .mask_in(blk_sel & ~blk_lock), .any_elig(any_elig), .last(last),
    .addr(mem_addr)
  );

  sig_misr u_misr (
    .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .seed(sig_wdata),
    .fold_en(fold_en), .din(mem_rdata), .sig(sig_value)
  );
endmodule

// File: rtl/sig_scan_chk.sv
module sig_scan_chk
  import sig_scan_pkg::*;
#(
  parameter int AW = 5,
  parameter int BLK_AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CTL_W-1:0] cfg_wdata,
  input logic [CTL_W-1:0] cfg_rdata,
  input logic             sig_we,
  input logic [SIG_W-1:0] sig_value,
  input logic             pe_any,
  input logic             mem_re,
  input logic [AW-1:0]    mem_addr,
  input logic             scan_asc
);
  // R4
  done_run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CTL_DONE] != cfg_rdata[CTL_RUN]);

  // R3
  pe_block_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[CTL_RUN] && pe_any && cfg_rdata[CTL_DONE]) |=> cfg_rdata[CTL_DONE]);

  // R5
  asc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && scan_asc && !(&mem_addr[BLK_AW-1:0])) |=> (mem_re && mem_addr == $past(mem_addr) + 1'b1));

  // R6
  rev_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !scan_asc) |=> !mem_re);

  // R8
  busy_order_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[CTL_DONE] |-> !cfg_rdata[CTL_ORDER]);

  // R7
  idle_sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[CTL_DONE] && !sig_we) |=> $stable(sig_value));

  // R2
  read_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !cfg_rdata[CTL_DONE]);
endmodule

bind sig_scan_engine sig_scan_chk #(.AW(AW), .BLK_AW(BLK_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .sig_we(sig_we), .sig_value(sig_value),
  .pe_any(pe_erase | pe_prog | pe_hv), .mem_re(mem_re), .mem_addr(mem_addr),
  .scan_asc(scan_asc)
);

// File: tb/sim_sig_scan_engine.sv
`timescale 1ns/1ps
module sim_sig_scan_engine;
  localparam int NB = 4;
  localparam int WB = 3;
  localparam int AW = 5;
  localparam int WPB = 1 << WB;

  logic clk, rst_n, cfg_we, sig_we, pe_erase, pe_prog, pe_hv, mem_re;
  logic [2:0] cfg_wdata, cfg_rdata;
  logic [31:0] sig_wdata, sig_value, mem_rdata;
  logic [NB-1:0] blk_sel, blk_lock;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0, cyc = 0, nlog = 0;
  logic [AW-1:0] alog [64];

  sig_scan_engine u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic [31:0] mem_word(input logic [AW-1:0] a);
    return (32'h9E37_79B9 * (32'(a) + 1)) ^ (32'(a) << 20);
  endfunction

  function automatic [31:0] fold(input [31:0] s, input [31:0] d);
    return ({s[30:0], 1'b0} ^ (s[31] ? 32'h0040_0007 : 32'h0)) ^ d;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= mem_word(mem_addr);
  always @(negedge clk) if (mem_re && nlog < 64) begin alog[nlog] = mem_addr; nlog++; end

  task automatic chk(input bit ok, input string req, input [63:0] act, input [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // runs one scan; poke exercises busy-time writes (R8)
  task automatic do_scan(input bit asc, input [NB-1:0] sel, input [NB-1:0] lock,
                         input [31:0] seed, input bit poke, input string tag);
    logic [NB-1:0] m;
    logic [31:0] exp_sig;
    int e, n, idx;
    bit seq_ok;
    @(negedge clk); sig_we = 1; sig_wdata = seed;
    @(negedge clk); sig_we = 0;
    blk_sel = sel; blk_lock = lock; cfg_we = 1; cfg_wdata = {asc, 1'b1, 1'b0}; nlog = 0;
    @(negedge clk); cfg_we = 0;
    blk_sel = ~sel; blk_lock = ~lock; // masks sampled at start (R2)
    n = 0;
    while (!cfg_rdata[0] && n < 1000) begin
      if (poke && n == 2) begin
        chk(cfg_rdata == 3'b010, "R8 busy read", cfg_rdata, 3'b010);
        cfg_we = 1; cfg_wdata = {~asc, 2'b10}; sig_we = 1; sig_wdata = ~seed;
      end
      if (poke && n == 3) begin cfg_we = 0; sig_we = 0; end
      @(negedge clk); n++;
    end
    m = sel & ~lock;
    e = 0; exp_sig = seed; seq_ok = 1; idx = 0;
    for (int b = 0; b < NB; b++) if (m[b]) for (int w = 0; w < WPB; w++) begin
      logic [WB-1:0] wv, rv;
      logic [AW-1:0] a;
      wv = WB'(w);
      for (int k = 0; k < WB; k++) rv[k] = wv[WB-1-k];
      a = {2'(b), asc ? wv : rv};
      if (idx >= nlog || alog[idx] != a) seq_ok = 0;
      exp_sig = fold(exp_sig, mem_word(a));
      idx++; e++;
    end
    if (nlog != e) seq_ok = 0;
    chk(seq_ok, {tag, " R2 address list"}, nlog, e);
    if (e == 0) chk(n == 1, {tag, " R9 empty done cycle"}, n, 1);
    else if (asc) chk(n == e + 1, {tag, " R5 done cycle"}, n, e + 1);
    else chk(n == 2 * e, {tag, " R6 done cycle"}, n, 2 * e);
    chk(sig_value == exp_sig, {tag, " R7 signature"}, sig_value, exp_sig);
    chk(cfg_rdata == {asc, 2'b01}, {tag, " R4 done/run after scan"}, cfg_rdata, {asc, 2'b01});
  endtask

  // {asc, sel, lock, seed}
  localparam logic [40:0] VEC [6] = '{
    {1'b1, 4'hF, 4'h0, 32'h0000_0000},
    {1'b0, 4'hF, 4'h0, 32'hFFFF_FFFF},
    {1'b1, 4'hA, 4'h2, 32'h1234_5678},
    {1'b0, 4'h5, 4'h0, 32'hDEAD_BEEF},
    {1'b1, 4'h9, 4'h8, 32'h8000_0001},
    {1'b0, 4'h6, 4'h4, 32'h0BAD_F00D}
  };

  initial begin
    rst_n = 0; cfg_we = 0; cfg_wdata = 0; sig_we = 0; sig_wdata = 0;
    pe_erase = 0; pe_prog = 0; pe_hv = 0; blk_sel = 0; blk_lock = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 3'b001, "R1 ctrl", cfg_rdata, 3'b001);
    chk(sig_value == 0, "R1 sig", sig_value, 0);
    chk(mem_re == 0, "R1 re", mem_re, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 6; i++)
      do_scan(VEC[i][40], VEC[i][39:36], VEC[i][35:32], VEC[i][31:0], 1'b0, $sformatf("vec%0d", i));

    // R3: each activity input blocks the start; order bit still written
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      pe_erase = (p == 0); pe_prog = (p == 1); pe_hv = (p == 2);
      blk_sel = 4'hF; blk_lock = 0; cfg_we = 1; cfg_wdata = 3'b110;
      @(negedge clk); cfg_we = 0;
      chk(cfg_rdata == 3'b101, "R3 start refused", cfg_rdata, 3'b101);
      @(negedge clk);
      chk(!mem_re && cfg_rdata[0], "R3 no read", mem_re, 0);
      pe_erase = 0; pe_prog = 0; pe_hv = 0;
    end

    // R8: busy writes to control and seed ignored
    do_scan(1'b1, 4'h3, 4'h0, 32'hCAFE_0001, 1'b1, "busy");
    // R9: nothing eligible
    do_scan(1'b0, 4'h3, 4'h3, 32'h5555_AAAA, 1'b0, "empty");
    // R7: seed load while idle
    @(negedge clk); sig_we = 1; sig_wdata = 32'h0F0F_1234;
    @(negedge clk); sig_we = 0;
    chk(sig_value == 32'h0F0F_1234, "R7 seed", sig_value, 32'h0F0F_1234);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule